// File: doc/BRIEF.md
# SPI Pin Path with Loopback

This block is an 8-bit SPI shift engine that works as either bus master or bus slave. Pin-path logic sits around it. A small control register decides where the shift register's serial input comes from. The input can be the external data pin, or the engine's own serial output fed straight back, with or without inversion. The register also decides what the master drives on MOSI while slave select is negated.

Software writes the control register only while the engine is switched off. Writes made while the engine is on are dropped. Frames use SPI mode 0, MSB first. In master mode SCK runs at a quarter of the system clock. A one-cycle done pulse marks the end of each frame, and the received byte is presented in that same cycle.

The self-feedback paths let a transfer be exercised without any external device. They also make the wire unable to disturb the received data. The fixed idle level keeps MOSI at a defined value between frames, instead of leaving the last transmitted bit on the line.

Top module: `spi_pinpath`

## Requirements
- R1: After reset the control register reads 0x00. Bit 0 selects inverted feedback, bit 1 selects plain feedback, bit 4 holds the idle level and bit 5 enables the idle level. Bits 2, 3, 6 and 7 always read 0.
- R2: A register write made while `spi_en` is 1 leaves the register contents unchanged.
- R3: A master frame shifts 8 bits out MSB first. MOSI is stable while SCK is high. The received byte appears on `rx_data` in the single cycle in which `done` is 1.
- R4: In master mode, SCK first rises 6 system clocks after `ss_n_o` falls. `ss_n_o` rises 4 system clocks after the last falling SCK edge. `ss_n_o` then stays high for at least 8 system clocks.
- R5: With bit 0 set and bit 1 clear, the master receives the bitwise inverse of its transmitted byte, and MISO has no effect.
- R6: With bit 1 set, the master receives exactly its transmitted byte, and MISO has no effect. This holds whatever the value of bit 0.
- R7: A slave with either feedback bit set ignores the MOSI pin. It receives its own byte, inverted when only bit 0 is set.
- R8: In master mode with bit 5 clear, MOSI carries bit 0 of the previous transmitted byte while slave select is negated.
- R9: In master mode with bit 5 set, MOSI carries the value of bit 4 during negation. It does the same during the burst hold between frames.
- R10: If `burst` is 1 when a master frame ends, `ss_n_o` stays low through the gap and in idle until `burst` drops.
- R11: A slave with both feedback bits clear samples MOSI on rising SCK. It shifts its byte out on MISO MSB first and pulses `done` after the eighth falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| spi_en | input | 1 | Engine enable; locks the register |
| master_sel | input | 1 | 1 = master role, 0 = slave role |
| start | input | 1 | Master: one-cycle pulse that starts a frame when idle |
| burst | input | 1 | Master: keep slave select asserted after a frame |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| sck_o | output | 1 | Master serial clock |
| ss_n_o | output | 1 | Master slave select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave select into the slave, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |

## Verification
The serial-input choice and the MOSI idle choice both read the control register at the end of a frame. The sample of the last bit and the load of the idle MOSI level fall on adjacent edges. The bench provokes this by setting the idle enable, an idle level that differs from the last transmitted bit, and a feedback mode, all together. It then checks that the received byte follows the feedback rule and that MOSI switches to the fixed level as soon as the frame's trailing period ends. In burst frames, the hold gap and the idle level overlap with slave select still asserted. The bench judges that case by sampling `ss_n_o` and `mosi_o` in the middle of the gap.

// File: rtl/spi_pinpath_pkg.sv
package spi_pinpath_pkg;

  typedef struct packed {
    logic fix_en;
    logic fix_lvl;
    logic lb_plain;
    logic lb_inv;
  } pin_cfg_t;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_LEAD  = 3'd1,
    M_BITS  = 3'd2,
    M_TRAIL = 3'd3,
    M_GAP   = 3'd4
  } mstate_t;

  // Serial input choice: plain feedback wins over inverted feedback.
  function automatic logic serial_in(input pin_cfg_t c, input logic sout,
                                     input logic pin);
    if (c.lb_plain) return sout;
    if (c.lb_inv)   return ~sout;
    return pin;
  endfunction

  // MOSI level while slave select is negated or held between frames.
  function automatic logic idle_mosi(input pin_cfg_t c, input logic last_bit);
    return c.fix_en ? c.fix_lvl : last_bit;
  endfunction

  function automatic logic [7:0] pack_cfg(input pin_cfg_t c);
    return {2'b00, c.fix_en, c.fix_lvl, 2'b00, c.lb_plain, c.lb_inv};
  endfunction

  function automatic pin_cfg_t unpack_cfg(input logic [7:0] d);
    pin_cfg_t c;
    c.lb_inv   = d[0];
    c.lb_plain = d[1];
    c.fix_lvl  = d[4];
    c.fix_en   = d[5];
    return c;
  endfunction

endpackage

// File: rtl/spi_pp_cfg_reg.sv
module spi_pp_cfg_reg
  import spi_pinpath_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       lock,
  output pin_cfg_t   cfg,
  output logic [7:0] rdata
);

  logic wr_accept;
  assign wr_accept = wr && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else if (wr_accept) cfg <= unpack_cfg(wdata);
  end

  assign rdata = pack_cfg(cfg);

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock) |=> $stable(rdata));

endmodule

// File: rtl/spi_pp_master.sv
module spi_pp_master
  import spi_pinpath_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DIV     = 4,
  parameter int GAP_SCK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic          burst,
  input  logic [DW-1:0] tx_data,
  input  pin_cfg_t      cfg,
  input  logic          miso,
  output logic          sck,
  output logic          ss_n,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_data
);

  localparam int HALF    = DIV / 2;
  localparam int GAP_LEN = DIV * GAP_SCK;
  localparam int CW      = (GAP_LEN > 2) ? $clog2(GAP_LEN) : 1;
  localparam int BW      = (DW > 2) ? $clog2(DW) : 1;

  mstate_t       st;
  logic [CW-1:0] tick;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sr;
  logic          samp;
  logic          last_bit;
  logic          hold;

  // named internal events
  logic sin, smp_ev, shf_ev, frame_end, in_frame, drive_data;
  assign sin        = serial_in(cfg, sr[DW-1], miso);
  assign smp_ev     = (st == M_BITS) && (tick == CW'(HALF - 1));
  assign shf_ev     = (st == M_BITS) && (tick == CW'(DIV - 1));
  assign frame_end  = (st == M_TRAIL) && (tick == CW'(DIV - 1));
  assign in_frame   = (st == M_LEAD) || (st == M_BITS) || (st == M_TRAIL);
  assign drive_data = (st == M_LEAD) || (st == M_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= M_IDLE; tick <= '0; bitn <= '0; sr <= '0; samp <= 1'b0;
      last_bit <= 1'b0; hold <= 1'b0; done <= 1'b0; rx_data <= '0;
    end else if (!run) begin
      st <= M_IDLE; tick <= '0; bitn <= '0; hold <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        M_IDLE: begin
          tick <= '0;
          if (!burst) hold <= 1'b0;
          if (start) begin
            sr <= tx_data;
            st <= M_LEAD;
          end
        end
        M_LEAD: begin
          if (tick == CW'(DIV - 1)) begin
            tick <= '0; bitn <= '0; st <= M_BITS;
          end else tick <= tick + 1'b1;
        end
        M_BITS: begin
          if (smp_ev) samp <= sin;
          if (shf_ev) begin
            tick     <= '0;
            last_bit <= sr[DW-1];
            sr       <= {sr[DW-2:0], samp};
            if (bitn == BW'(DW - 1)) st <= M_TRAIL;
            else bitn <= bitn + 1'b1;
          end else tick <= tick + 1'b1;
        end
        M_TRAIL: begin
          if (frame_end) begin
            tick <= '0; done <= 1'b1; rx_data <= sr; hold <= burst;
            st <= M_GAP;
          end else tick <= tick + 1'b1;
        end
        M_GAP: begin
          if (tick == CW'(GAP_LEN - 1)) begin
            tick <= '0; st <= M_IDLE;
          end else tick <= tick + 1'b1;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  assign sck  = (st == M_BITS) && (tick >= CW'(HALF));
  assign ss_n = !(in_frame || hold);

  always_comb begin
    if (drive_data)        mosi = sr[DW-1];
    else if (st == M_TRAIL) mosi = last_bit;
    else                   mosi = idle_mosi(cfg, last_bit);
  end

  // R4
  sck_inside_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !ss_n);

  // R4
  min_negation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(ss_n)) |=> ss_n);

  // R3
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && cfg.fix_en) |-> (mosi == cfg.fix_lvl));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && !cfg.fix_en && !$past(cfg.fix_en)) |-> $stable(mosi));

endmodule

// File: rtl/spi_pp_slave.sv
module spi_pp_slave
  import spi_pinpath_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] tx_data,
  input  pin_cfg_t      cfg,
  input  logic          sck_pin,
  input  logic          ss_n_pin,
  input  logic          mosi_pin,
  output logic          miso,
  output logic          done,
  output logic [DW-1:0] rx_data
);

  localparam int BW = (DW > 2) ? $clog2(DW) : 1;

  logic [2:0]    sck_q, ss_q;
  logic [1:0]    mosi_q;
  logic [DW-1:0] sr;
  logic [BW-1:0] bitn;
  logic          samp;

  logic active, sel_fall, sck_rise, sck_fall, sin, last_shift;
  assign active     = !ss_q[1];
  assign sel_fall   = !ss_q[1] && ss_q[2];
  assign sck_rise   = sck_q[1] && !sck_q[2];
  assign sck_fall   = !sck_q[1] && sck_q[2];
  assign sin        = serial_in(cfg, sr[DW-1], mosi_q[1]);
  assign last_shift = active && sck_fall && (bitn == BW'(DW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 3'b000; ss_q <= 3'b111; mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck_pin};
      ss_q   <= {ss_q[1:0], ss_n_pin};
      mosi_q <= {mosi_q[0], mosi_pin};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; bitn <= '0; samp <= 1'b0; done <= 1'b0; rx_data <= '0;
    end else if (!run) begin
      bitn <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sel_fall) begin
        sr   <= tx_data;
        bitn <= '0;
      end else if (active && sck_rise) begin
        samp <= sin;
      end else if (active && sck_fall) begin
        sr <= {sr[DW-2:0], samp};
        if (last_shift) begin
          done    <= 1'b1;
          rx_data <= {sr[DW-2:0], samp};
          bitn    <= '0;
        end else bitn <= bitn + 1'b1;
      end
    end
  end

  assign miso = (run && active) ? sr[DW-1] : 1'b0;

  // R11
  slave_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  slave_done_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(active));

endmodule

// File: rtl/spi_pinpath.sv
module spi_pinpath
  import spi_pinpath_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DIV     = 4,
  parameter int GAP_SCK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          spi_en,
  input  logic          master_sel,
  input  logic          start,
  input  logic          burst,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          sck_o,
  output logic          ss_n_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o
);

  pin_cfg_t      cfg;
  logic          m_run, s_run;
  logic          m_mosi, m_done, s_done;
  logic [DW-1:0] m_rx, s_rx;

  assign m_run = spi_en && master_sel;
  assign s_run = spi_en && !master_sel;

  spi_pp_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .lock(spi_en), .cfg(cfg), .rdata(reg_rdata)
  );

  spi_pp_master #(.DW(DW), .DIV(DIV), .GAP_SCK(GAP_SCK)) u_master (
    .clk(clk), .rst_n(rst_n), .run(m_run), .start(start), .burst(burst),
    .tx_data(tx_data), .cfg(cfg), .miso(miso_i), .sck(sck_o),
    .ss_n(ss_n_o), .mosi(m_mosi), .done(m_done), .rx_data(m_rx)
  );

  spi_pp_slave #(.DW(DW)) u_slave (
    .clk(clk), .rst_n(rst_n), .run(s_run), .tx_data(tx_data), .cfg(cfg),
    .sck_pin(sck_i), .ss_n_pin(ss_n_i), .mosi_pin(mosi_i), .miso(miso_o),
    .done(s_done), .rx_data(s_rx)
  );

  assign mosi_o  = master_sel ? m_mosi : 1'b0;
  assign done    = master_sel ? m_done : s_done;
  assign rx_data = master_sel ? m_rx : s_rx;

endmodule

// File: tb/spi_pinpath_bench.sv
module spi_pinpath_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_en = 1'b0;
  logic       master_sel = 1'b1;
  logic       start = 1'b0;
  logic       burst = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       done;
  logic       sck_o, ss_n_o, mosi_o, miso_i, miso_o;
  logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_ssfall = 0, t_rise1 = 0, t_lastfall = 0, t_ssrise = 0;
  bit got_rise = 1'b0;
  bit p_ss = 1'b1, p_sck = 1'b0;
  logic [7:0] cap = 8'h00;
  logic [7:0] mdl = 8'h00;

  always #5 clk = ~clk;

  assign miso_i = mdl[7];

  spi_pinpath u_spi_pinpath (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_en(spi_en), .master_sel(master_sel),
    .start(start), .burst(burst), .tx_data(tx_data), .rx_data(rx_data),
    .done(done), .sck_o(sck_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o)
  );

  // pin monitor and external slave model
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (p_ss && !ss_n_o) begin t_ssfall = cyc; got_rise = 1'b0; end
    if (!p_sck && sck_o) begin
      cap = {cap[6:0], mosi_o};
      if (!got_rise) begin t_rise1 = cyc; got_rise = 1'b1; end
    end
    if (p_sck && !sck_o) begin t_lastfall = cyc; mdl = {mdl[6:0], 1'b0}; end
    if (!p_ss && ss_n_o) t_ssrise = cyc;
    p_ss = ss_n_o; p_sck = sck_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk); spi_en = 1'b0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0; spi_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] pat,
                            input bit bst, input bit timing,
                            input logic [7:0] exp_rx, input bit exp_idle,
                            input string req);
    @(negedge clk);
    master_sel = 1'b1; tx_data = tx; mdl = pat; burst = bst; start = 1'b1;
    @(negedge clk); start = 1'b0;
    do begin @(negedge clk); #1; end while (!done);
    chk(rx_data == exp_rx, req, rx_data, exp_rx);
    chk(cap == tx, "R3 mosi bits", cap, tx);
    if (timing) begin
      chk(t_rise1 - t_ssfall == 6, "R4 lead", t_rise1 - t_ssfall, 6);
      chk(t_ssrise - t_lastfall == 4, "R4 trail", t_ssrise - t_lastfall, 4);
    end
    @(negedge clk); #1;
    chk(done == 1'b0, "R3 done width", done, 0);
    @(negedge clk); #1;
    chk(ss_n_o == !bst, "R10 ss during gap", ss_n_o, !bst);
    chk(mosi_o == exp_idle, bst ? "R9 idle in burst hold" : "R8/R9 idle mosi",
        mosi_o, exp_idle);
    repeat (10) @(negedge clk);
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] din,
                           input logic [7:0] exp_rx, input string req);
    logic [7:0] got;
    master_sel = 1'b0;
    @(negedge clk); tx_data = tx; ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = din[i];
      repeat (4) @(negedge clk);
      got[i] = miso_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    #1;
    chk(rx_data == exp_rx, req, rx_data, exp_rx);
    chk(got == tx, "R11 miso bits", got, tx);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic test_reset;
    #1;
    chk(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 8'h00);
    chk(ss_n_o == 1'b1 && sck_o == 1'b0 && done == 1'b0, "R1 reset pins",
        {ss_n_o, sck_o, done}, 3'b100);
  endtask

  task automatic test_register;
    set_cfg(8'hFF);
    chk(reg_rdata == 8'h33, "R1 reserved read 0", reg_rdata, 8'h33);
    set_cfg(8'h12);
    chk(reg_rdata == 8'h12, "R1 field write", reg_rdata, 8'h12);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h21;
    @(negedge clk); reg_wr = 1'b0; #1;
    chk(reg_rdata == 8'h12, "R2 write while enabled", reg_rdata, 8'h12);
  endtask

  task automatic test_master_plain;
    set_cfg(8'h00);
    run_master(8'hA5, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b1, "R3 rx normal");
    run_master(8'h5A, 8'hC9, 1'b0, 1'b1, 8'hC9, 1'b0, "R3 rx normal 2");
  endtask

  task automatic test_master_loop;
    set_cfg(8'h01);
    run_master(8'hC3, 8'hFF, 1'b0, 1'b0, 8'h3C, 1'b1, "R5 inverted loop");
    set_cfg(8'h02);
    run_master(8'h96, 8'h00, 1'b0, 1'b0, 8'h96, 1'b0, "R6 plain loop");
    set_cfg(8'h03);
    run_master(8'h4E, 8'hB1, 1'b0, 1'b0, 8'h4E, 1'b0, "R6 plain priority");
  endtask

  task automatic test_idle_fix;
    set_cfg(8'h30);
    run_master(8'h02, 8'h55, 1'b0, 1'b0, 8'h55, 1'b1, "R9 fixed high rx");
    set_cfg(8'h21);
    run_master(8'h81, 8'h00, 1'b0, 1'b0, 8'h7E, 1'b0, "R9 fixed low with loop");
  endtask

  task automatic test_burst;
    set_cfg(8'h30);
    run_master(8'h12, 8'h34, 1'b1, 1'b0, 8'h34, 1'b1, "R10 burst frame 1");
    chk(ss_n_o == 1'b0, "R10 ss held in idle", ss_n_o, 0);
    run_master(8'h56, 8'h78, 1'b1, 1'b0, 8'h78, 1'b1, "R10 burst frame 2");
    @(negedge clk); burst = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(ss_n_o == 1'b1, "R10 ss released", ss_n_o, 1);
    chk(mosi_o == 1'b1, "R9 idle after release", mosi_o, 1);
  endtask

  task automatic test_slave;
    set_cfg(8'h00);
    run_slave(8'h6B, 8'hD4, 8'hD4, "R11 slave rx");
    set_cfg(8'h01);
    run_slave(8'h81, 8'hFF, 8'h7E, "R7 slave inverted loop");
    set_cfg(8'h02);
    run_slave(8'h81, 8'h00, 8'h81, "R7 slave plain loop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset;
    test_register;
    test_master_plain;
    test_master_loop;
    test_idle_fix;
    test_burst;
    test_slave;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule